// File: doc/BRIEF.md
# Serial Command Receiver with Double-Entry Check

This block is the host-facing command port of a multi-channel playback controller. A host microcontroller clocks bytes into it over a clock-synchronous serial link (serial clock, active-low select, data in, data out). The block oversamples the link in its own system clock domain, assembles bytes MSB first, works out from the upper nibble of the first byte how many bytes the command has, and, once the last byte has arrived, presents the whole command for one cycle as a strobe with the opcode, the low nibble of the first byte and up to two payload bytes.

After every byte it pulls an active-low busy line for a fixed number of system cycles, and the host waits for that line to return high before it clocks the next byte. Three opcodes are status reads: for them the byte that follows is a read slot, in which the host keeps its data line low while the block drives a status byte out on the data-out line with an output enable raised. A mode input turns on double entry, in which a command is acted on only after the host has sent it twice with identical bytes; a differing second copy throws both away and pulses a mismatch flag.

Top module: `cmdrx_top`

## Requirements
- R1: After reset, `busy_n` is 1, `so_oe` is 0, and `cmd_valid` and `dbl_err` are 0.
- R2: Input bits are taken on the falling edge of `sck` while `csb` is low, most significant bit first; eight falling edges make one byte.
- R3: The length of a command comes from bits 7:4 of its first byte: opcodes 0x0, 0x2, 0x5, 0x6, 0x7 and 0x8 are one byte; 0x1, 0x3, 0x4, 0x9 and 0xF are two bytes; 0xD and 0xE are three bytes; 0xA, 0xB and 0xC are read commands of one byte followed by a read slot. No command is presented before its last byte.
- R4: A complete command is presented by `cmd_valid` high for exactly one cycle, with `cmd_op` = first byte bits 7:4, `cmd_arg` = first byte bits 3:0, `cmd_b1` and `cmd_b2` = second and third bytes (zero where the command is shorter) and `cmd_len` = number of bytes (1 for read commands).
- R5: After the eighth falling edge of each byte, read slots included, `busy_n` goes low for exactly `BUSY_CYC` system cycles and then returns high.
- R6: Raising `csb` discards a partly received byte and a partly received command; with `csb` held low, commands follow each other by byte counting alone.
- R7: After a read command, the next byte on the link is a read slot: the block raises `so_oe`, loads `rd_data`, and drives it on `so` MSB first, one bit per rising edge of `sck`; the bits on `si` during the slot are ignored and form no command.
- R8: With `dbl_mode` high, a non-read command is presented only after it has been received twice with identical bytes, and is then presented once.
- R9: With `dbl_mode` high, if the second copy differs from the first, both are discarded, no command is presented, `dbl_err` pulses for one cycle, and the next command starts a fresh pair.
- R10: `so_oe` is low at all times other than from a read command's acceptance to the eighth falling edge of its read slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, idle low |
| csb | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial read-back data |
| so_oe | output | 1 | Output enable for `so` (pad is tri-stated when low) |
| busy_n | output | 1 | Low while a received byte is processed |
| dbl_mode | input | 1 | Enables double-entry acceptance |
| rd_data | input | 8 | Status byte to return in a read slot |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Opcode of the presented command |
| cmd_arg | output | 4 | Low nibble of the first byte |
| cmd_b1 | output | 8 | Second command byte |
| cmd_b2 | output | 8 | Third command byte |
| cmd_len | output | 2 | Byte count of the presented command |
| dbl_err | output | 1 | One-cycle pulse when two copies differ |

## Verification
A table of commands covering every length class, with first bytes whose low nibbles and payloads mix set and clear bits, tells apart correct length decoding from early or late completion and catches swapped or shifted payload fields. Reads are run with the data line both low and high during the slot, which separates a properly ignored slot from one decoded as a command, and with two status patterns so that bit order and alignment on the output show. Select aborts mid-byte and mid-command tell framing by select apart from framing by count, and the double-entry pairs, matching and differing, tell acceptance on the second copy from acceptance on the first.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;

  // Number of bytes a command occupies, keyed by its opcode nibble.
  function automatic logic [1:0] op_len(input logic [OP_W-1:0] op);
    case (op)
      4'h1, 4'h3, 4'h4, 4'h9, 4'hF: op_len = 2'd2;
      4'hD, 4'hE:                   op_len = 2'd3;
      default:                      op_len = 2'd1;
    endcase
  endfunction

  // Opcodes followed by a read slot.
  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    op_is_read = (op == 4'hA) || (op == 4'hB) || (op == 4'hC);
  endfunction
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csb,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE_V = 3'b010; // {sck, csb, si}

  logic [W-1:0] stg [STAGES];
  logic         sck_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= IDLE_V;
          else     stg[g] <= {sck, csb, si};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= IDLE_V;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= stg[STAGES-1][2];
  end

  assign sck_rise = stg[STAGES-1][2] & ~sck_prev;
  assign sck_fall = ~stg[STAGES-1][2] & sck_prev;
  assign cs_act   = ~stg[STAGES-1][1];
  assign si_s     = stg[STAGES-1][0];
endmodule

// File: rtl/cmdrx_shift.sv
module cmdrx_shift
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              load_slot,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              byte_done,
  output logic              slot_end,
  output logic [BYTE_W-1:0] byte_q,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] out_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      out_sh    <= '0;
      byte_q    <= '0;
      byte_done <= 1'b0;
      slot_end  <= 1'b0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      slot_end  <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        so_oe   <= 1'b0;
        so      <= 1'b0;
      end else begin
        if (load_slot) begin
          so_oe  <= 1'b1;
          out_sh <= rd_data;
        end
        if (sck_rise && so_oe) begin
          so     <= out_sh[BYTE_W-1];
          out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
        end
        if (sck_fall) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (!so_oe) byte_q <= {byte_q[BYTE_W-2:0], si_s};
          if (bit_cnt == LAST_BIT) begin
            if (so_oe) begin
              so_oe    <= 1'b0;
              slot_end <= 1'b1;
            end else begin
              byte_done <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdrx_frame.sv
module cmdrx_frame
  import cmdrx_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic              slot_end,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              dbl_mode,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [OP_W-1:0]   cmd_arg,
  output logic [BYTE_W-1:0] cmd_b1,
  output logic [BYTE_W-1:0] cmd_b2,
  output logic [1:0]        cmd_len,
  output logic              dbl_err,
  output logic              busy_n,
  output logic              load_slot
);
  localparam int BC_W = $clog2(BUSY_CYC + 1);
  localparam logic [BC_W-1:0] BC_INIT = BC_W'(BUSY_CYC - 1);

  logic [1:0]          pos;
  logic [BYTE_W-1:0]   b0, b1;
  logic                pend;
  logic [3*BYTE_W-1:0] pcopy;
  logic [BC_W-1:0]     bcnt;

  logic [BYTE_W-1:0]   nb0, nb1, nb2;
  logic [1:0]          nlen;
  logic                nrd, last, same;

  always_comb begin
    nb0  = (pos == 2'd0) ? byte_q : b0;
    nb1  = (pos == 2'd1) ? byte_q : ((pos == 2'd0) ? '0 : b1);
    nb2  = (pos == 2'd2) ? byte_q : '0;
    nlen = op_len(nb0[BYTE_W-1 -: OP_W]);
    nrd  = op_is_read(nb0[BYTE_W-1 -: OP_W]);
    last = ((pos + 2'd1) == nlen);
    same = ({nb0, nb1, nb2} == pcopy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0; b0 <= '0; b1 <= '0; pend <= 1'b0; pcopy <= '0;
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_arg <= '0;
      cmd_b1 <= '0; cmd_b2 <= '0; cmd_len <= '0;
      dbl_err <= 1'b0; load_slot <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      dbl_err   <= 1'b0;
      load_slot <= 1'b0;
      if (!cs_act) begin
        pos  <= '0;
        pend <= 1'b0;
      end else if (byte_done) begin
        if (pos == 2'd0) b0 <= byte_q;
        if (pos == 2'd1) b1 <= byte_q;
        if (!last) begin
          pos <= pos + 2'd1;
        end else begin
          pos <= '0;
          if (nrd || !dbl_mode || (pend && same)) begin
            cmd_valid <= 1'b1;
            cmd_op    <= nb0[BYTE_W-1 -: OP_W];
            cmd_arg   <= nb0[OP_W-1:0];
            cmd_b1    <= nb1;
            cmd_b2    <= nb2;
            cmd_len   <= nlen;
            load_slot <= nrd;
            if (!nrd) pend <= 1'b0;
          end else if (!pend) begin
            pend  <= 1'b1;
            pcopy <= {nb0, nb1, nb2};
          end else begin
            pend    <= 1'b0;
            dbl_err <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n <= 1'b1;
      bcnt   <= '0;
    end else if (byte_done || slot_end) begin
      busy_n <= 1'b0;
      bcnt   <= BC_INIT;
    end else if (!busy_n) begin
      if (bcnt == '0) busy_n <= 1'b1;
      else            bcnt   <= bcnt - 1'b1;
    end
  end

  // R4
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R9
  err_excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && dbl_err));
  // R5
  busy_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done || slot_end) |=> !busy_n);
endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
  import cmdrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              csb,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              busy_n,
  input  logic              dbl_mode,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [OP_W-1:0]   cmd_arg,
  output logic [BYTE_W-1:0] cmd_b1,
  output logic [BYTE_W-1:0] cmd_b2,
  output logic [1:0]        cmd_len,
  output logic              dbl_err
);
  logic sck_rise, sck_fall, cs_act, si_s;
  logic byte_done, slot_end, load_slot;
  logic [BYTE_W-1:0] byte_q;

  cmdrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .csb(csb), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_s(si_s)
  );

  cmdrx_shift u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .load_slot(load_slot),
    .rd_data(rd_data), .byte_done(byte_done), .slot_end(slot_end),
    .byte_q(byte_q), .so(so), .so_oe(so_oe)
  );

  cmdrx_frame #(.BUSY_CYC(BUSY_CYC)) u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .byte_done(byte_done),
    .slot_end(slot_end), .byte_q(byte_q), .dbl_mode(dbl_mode),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .cmd_len(cmd_len),
    .dbl_err(dbl_err), .busy_n(busy_n), .load_slot(load_slot)
  );

  // R7
  slot_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> $past(load_slot));
endmodule

// File: tb/cmdrx_top_bench.sv
module cmdrx_top_bench;
  localparam int BUSY_CYC = 4;

  logic clk = 1'b0;
  logic rst, sck, csb, si, dbl_mode;
  logic [7:0] rd_data;
  logic so, so_oe, busy_n, cmd_valid, dbl_err;
  logic [3:0] cmd_op, cmd_arg;
  logic [7:0] cmd_b1, cmd_b2;
  logic [1:0] cmd_len;

  always #10 clk = ~clk;

  cmdrx_top #(.SYNC_STAGES(2), .BUSY_CYC(BUSY_CYC)) u_cmdrx_top (
    .clk(clk), .rst(rst), .sck(sck), .csb(csb), .si(si), .so(so),
    .so_oe(so_oe), .busy_n(busy_n), .dbl_mode(dbl_mode), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .cmd_len(cmd_len), .dbl_err(dbl_err)
  );

  // {length, byte0, byte1, byte2}
  localparam logic [25:0] VEC [12] = '{
    {2'd1, 8'h05, 8'h00, 8'h00}, {2'd2, 8'h4A, 8'h37, 8'h00},
    {2'd1, 8'h5F, 8'h00, 8'h00}, {2'd1, 8'h6C, 8'h00, 8'h00},
    {2'd3, 8'hD3, 8'h12, 8'h34}, {2'd3, 8'hE0, 8'hFF, 8'h01},
    {2'd2, 8'h1B, 8'h80, 8'h00}, {2'd1, 8'h87, 8'h00, 8'h00},
    {2'd2, 8'h9F, 8'h00, 8'h00}, {2'd2, 8'hF1, 8'hC3, 8'h00},
    {2'd1, 8'h22, 8'h00, 8'h00}, {2'd2, 8'h3E, 8'h5A, 8'h00}
  };

  int n_chk = 0, n_fail = 0, n_valid = 0, n_err = 0;
  bit done = 0, oe_seen = 0;
  logic [3:0] l_op, l_arg;
  logic [7:0] l_b1, l_b2;
  logic [1:0] l_len;

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_valid++;
      l_op = cmd_op; l_arg = cmd_arg; l_b1 = cmd_b1; l_b2 = cmd_b2; l_len = cmd_len;
    end
    if (dbl_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(output int lowc);
    int t = 0;
    while (busy_n && t < 30) begin @(negedge clk); t++; end
    lowc = 0;
    while (!busy_n && lowc < 100) begin @(negedge clk); lowc++; end
  endtask

  task automatic clk_bit(input logic b);
    si = b; repeat (4) @(negedge clk);
    sck = 1'b1; repeat (4) @(negedge clk);
    if (so_oe) oe_seen = 1;
    sck = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, output int lowc);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    wait_busy(lowc);
  endtask

  task automatic send(input logic [7:0] v);
    int lc;
    send_byte(v, lc);
  endtask

  task automatic read_slot(input logic siv, output logic [7:0] v);
    int lc;
    for (int i = 7; i >= 0; i--) begin
      si = siv; repeat (4) @(negedge clk);
      sck = 1'b1; repeat (4) @(negedge clk);
      v[i] = so;
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    wait_busy(lc);
  endtask

  task automatic cs_toggle();
    csb = 1'b1; repeat (6) @(negedge clk);
    csb = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lc, base, eb;
    logic [7:0] rv;
    rst = 1'b1; sck = 1'b0; csb = 1'b1; si = 1'b0; dbl_mode = 1'b0; rd_data = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy_n == 1'b1 && so_oe == 1'b0, "R1 idle outputs", {busy_n, so_oe}, 2'b10);
    chk(cmd_valid == 1'b0 && dbl_err == 1'b0, "R1 strobes", {cmd_valid, dbl_err}, 0);

    csb = 1'b0; repeat (4) @(negedge clk);
    // R5 busy width
    send_byte(8'h05, lc);
    chk(lc == BUSY_CYC, "R5 busy low cycles", lc, BUSY_CYC);

    // R2 R3 R4 table walk with select held low
    for (int k = 0; k < 12; k++) begin
      logic [1:0] ln;
      logic [7:0] e0, e1, e2;
      {ln, e0, e1, e2} = VEC[k];
      base = n_valid;
      send(e0);
      if (ln > 2'd1) send(e1);
      if (ln > 2'd2) begin
        chk(n_valid == base, "R3 no early completion", n_valid, base);
        send(e2);
      end
      if (ln == 2'd2) chk(n_valid == base + 1, "R3 two-byte count", n_valid, base + 1);
      else chk(n_valid == base + 1, "R3 completion count", n_valid, base + 1);
      chk(l_op == e0[7:4] && l_arg == e0[3:0], "R2 first byte fields", {l_op, l_arg}, e0);
      chk(l_b1 == e1 && l_b2 == e2, "R4 payload bytes", {l_b1, l_b2}, {e1, e2});
      chk(l_len == ln, "R4 length", l_len, ln);
    end
    chk(oe_seen == 1'b0, "R10 no output enable on command bytes", oe_seen, 0);

    // R6 abort mid-byte
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
    cs_toggle();
    base = n_valid;
    send(8'h55);
    chk(n_valid == base + 1 && l_op == 4'h5 && l_arg == 4'h5, "R6 mid-byte abort", {l_op, l_arg}, 8'h55);
    // R6 abort mid-command
    send(8'h4A);
    cs_toggle();
    base = n_valid;
    send(8'h60);
    chk(n_valid == base + 1 && l_op == 4'h6 && l_len == 2'd1, "R6 mid-command abort", {l_op, l_len}, 6'h19);

    // R7 read slot, data line high during slot
    rd_data = 8'hA5;
    base = n_valid;
    send(8'hA0);
    chk(n_valid == base + 1 && l_op == 4'hA && l_len == 2'd1, "R7 read strobe", {l_op, l_len}, 6'h29);
    chk(so_oe == 1'b1, "R7 enable in slot", so_oe, 1);
    read_slot(1'b1, rv);
    chk(rv == 8'hA5, "R7 read data", rv, 8'hA5);
    chk(so_oe == 1'b0, "R10 enable drops after slot", so_oe, 0);
    chk(n_valid == base + 1, "R7 slot bits ignored", n_valid, base + 1);
    rd_data = 8'h3C;
    send(8'hB0);
    read_slot(1'b0, rv);
    chk(rv == 8'h3C, "R7 second read data", rv, 8'h3C);
    base = n_valid;
    send(8'h87);
    chk(n_valid == base + 1 && l_op == 4'h8 && l_arg == 4'h7, "R7 framing after slot", {l_op, l_arg}, 8'h87);

    // R8 double entry
    csb = 1'b1; dbl_mode = 1'b1; repeat (6) @(negedge clk);
    csb = 1'b0; repeat (4) @(negedge clk);
    base = n_valid;
    send(8'h4A); send(8'h37);
    chk(n_valid == base, "R8 first copy held", n_valid, base);
    send(8'h4A); send(8'h37);
    chk(n_valid == base + 1 && l_op == 4'h4 && l_b1 == 8'h37, "R8 accepted on second copy", {l_op, l_b1}, 12'h437);

    // R9 mismatch
    base = n_valid; eb = n_err;
    send(8'h5F); send(8'h5E);
    chk(n_valid == base, "R9 mismatch not presented", n_valid, base);
    chk(n_err == eb + 1, "R9 mismatch flag", n_err, eb + 1);
    send(8'h6C);
    chk(n_valid == base, "R9 fresh pair first copy", n_valid, base);
    send(8'h6C);
    chk(n_valid == base + 1 && l_op == 4'h6 && l_arg == 4'hC, "R9 fresh pair accepted", {l_op, l_arg}, 8'h6C);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule